// File: doc/BRIEF.md
# Bit-Level Two-Wire Target to Transaction Bridge

This block sits on the target side of a two-wire serial bus (I2C style). It watches a clock level and a data level that a host moves one step at a time, as though it were bit-banging the bus from general-purpose pins. From the changes on those two levels it decodes start and stop conditions, shifts bytes in and out, and answers acknowledge clocks. Each completed protocol step becomes a one-cycle request on a downstream transaction port: open a transfer with a 7-bit target address and a direction flag, write a byte, fetch a byte to be read, report that the host refused further read data, or close the transfer.

The block does not oversample. It compares each input with its value from the previous cycle and acts only when a level changes. All protocol decisions are made on a rising clock level. On every falling clock level the block lets go of the data line. The data level reported back to the host is a wired-AND of the host's own data level and the block's drive. The downstream answers within the same cycle as the request: an accept/reject flag for address and write bytes, and the byte for a fetch.

Top module: `i2c_xact_bridge`

## Requirements
- R1: During and right after reset, `sda_o` is 1 and no request output is asserted. The host levels seen by the block start at 1.
- R2: A falling `sda_i` while `scl_i` is high is a start condition. The next byte is treated as an address byte, including after a start repeated inside a transfer.
- R3: A rising `sda_i` while `scl_i` is high is a stop condition. It pulses `req_end` only if an address is currently held, then returns the block to idle.
- R4: A change of `sda_i` while `scl_i` is low, or an input that keeps its level, raises no request and leaves the block's drive unchanged.
- R5: Written bits are sampled on each `scl_i` rise and shifted in MSB first. On the ninth rise, the first byte after a start pulses `req_start` with `req_addr` = byte bits 7:1 and `req_read` = byte bit 0 (1 = read). Each later byte pulses `req_write` with `req_wdata` = the byte.
- R6: When the downstream accepts (`rsp_nack` = 0), `sda_o` goes low from the ninth rise and returns to 1 after the next `scl_i` fall.
- R7: When the downstream rejects an address or write byte, the block pulses `req_end` in that cycle and keeps `sda_o` at 1. It then ignores clocks until the next start.
- R8: After an accepted read address, the first read rise pulses `req_fetch` and latches `rsp_rdata`. The byte appears on `sda_o` MSB first, one bit per rise, over eight rises.
- R9: On the ninth clock of a read byte, a low `sda_i` (host acknowledge) continues with a new fetch. A high `sda_i` pulses `req_mnack` and parks the block: later clocks raise no request and leave `sda_o` at 1 until a start. A stop while parked still pulses `req_end`.
- R10: When `scl_i` and `sda_i` change in the same cycle, the data change is decoded first. So both lines falling together from idle is a start followed by a clock fall.
- R11: `sda_o` equals the block's drive ANDed with the host's latest `sda_i`, one cycle after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Host clock level |
| sda_i | input | 1 | Host data level |
| sda_o | output | 1 | Resolved data level (host AND block drive), registered |
| req_start | output | 1 | Pulse: open transfer with address and direction |
| req_addr | output | DW-1 | Target address for `req_start` |
| req_read | output | 1 | Direction for `req_start`, 1 = read |
| req_write | output | 1 | Pulse: write byte |
| req_wdata | output | DW | Byte for `req_write` |
| rsp_nack | input | 1 | Same-cycle reject of `req_start` or `req_write` |
| req_fetch | output | 1 | Pulse: fetch a read byte |
| rsp_rdata | input | DW | Same-cycle byte for `req_fetch` |
| req_mnack | output | 1 | Pulse: host refused further read data |
| req_end | output | 1 | Pulse: close the transfer |

## Verification
A wrong bit count or shift direction shows up on the ninth clock of the first byte. There it produces a wrong address on `req_start`, or an acknowledge on `sda_o` in the wrong clock. A state that misses a start or stop condition shows up as a missing or extra `req_end` when the transfer closes. A wrong read-state sequence shows up within one byte as a wrong bit on `sda_o` after an `scl_i` rise, or a `req_fetch` at the wrong time. Clocks given while parked or after a reject must leave `sda_o` high and every request low. This shows at once whether the block really stops decoding.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no transfer, clocks ignored
    ST_WBIT,   // host shifting a byte in
    ST_WACK,   // ninth clock of a host byte
    ST_RBIT,   // block shifting a byte out
    ST_MACK,   // ninth clock of a read byte
    ST_PARK    // host refused data, wait for start/stop
  } st_e;
endpackage

// File: rtl/i2cb_lines.sv
module i2cb_lines (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_chg,
  output logic cond_start,
  output logic cond_stop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise   = !scl_q && scl_i;
  assign scl_fall   = scl_q && !scl_i;
  assign sda_chg    = sda_q != sda_i;
  // data change decoded against the clock level before any same-cycle clock change
  assign cond_start = sda_chg && scl_q && !sda_i;
  assign cond_stop  = sda_chg && scl_q && sda_i;

  a_r2_start_needs_high_clk: assert property (@(posedge clk) disable iff (rst)
    cond_start |=> !sda_q);
  a_r3_start_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cond_start && cond_stop));
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_i,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          cond_start,
  input  logic          cond_stop,
  input  logic          rsp_nack,
  input  logic [DW-1:0] rsp_rdata,
  output logic          req_start,
  output logic [DW-2:0] req_addr,
  output logic          req_read,
  output logic          req_write,
  output logic [DW-1:0] req_wdata,
  output logic          req_fetch,
  output logic          req_mnack,
  output logic          req_end,
  output logic          sda_o
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  st_e           st_q, st_a, st_d;
  logic [CW-1:0] cnt_q, cnt_a, cnt_d;
  logic [DW-1:0] sh_q, sh_d, rbyte;
  logic          av_q, av_a, av_d;    // address held
  logic          rd_q, rd_d;          // transfer direction
  logic          drv_q, drv_d;        // block's own drive
  logic          rd_next;

  assign req_addr  = sh_q[DW-1:1];
  assign req_read  = sh_q[0];
  assign req_wdata = sh_q;
  assign rbyte     = (cnt_q == '0) ? rsp_rdata : sh_q;
  assign rd_next   = av_a ? rd_q : sh_q[0];

  always_comb begin
    // data line events first
    st_a = st_q;
    cnt_a = cnt_q;
    av_a = av_q;
    drv_d = drv_q;
    req_end = 1'b0;
    if (cond_start) begin
      st_a = ST_WBIT;
      cnt_a = '0;
      av_a = 1'b0;
      drv_d = 1'b1;
    end else if (cond_stop) begin
      req_end = av_q;
      st_a = ST_IDLE;
      av_a = 1'b0;
      drv_d = 1'b1;
    end
    // then the clock line
    st_d = st_a;
    cnt_d = cnt_a;
    av_d = av_a;
    rd_d = rd_q;
    sh_d = sh_q;
    req_start = 1'b0;
    req_write = 1'b0;
    req_fetch = 1'b0;
    req_mnack = 1'b0;
    if (scl_fall) drv_d = 1'b1;
    if (scl_rise) begin
      drv_d = 1'b1;
      unique case (st_a)
        ST_WBIT: begin
          sh_d = {sh_q[DW-2:0], sda_i};
          cnt_d = cnt_a + 1'b1;
          if (cnt_a == LAST) st_d = ST_WACK;
        end
        ST_WACK: begin
          req_start = !av_a;
          req_write = av_a;
          if (rsp_nack) begin
            req_end = 1'b1;
            av_d = 1'b0;
            st_d = ST_IDLE;
          end else begin
            av_d = 1'b1;
            rd_d = rd_next;
            drv_d = 1'b0;
            cnt_d = '0;
            st_d = rd_next ? ST_RBIT : ST_WBIT;
          end
        end
        ST_RBIT: begin
          req_fetch = (cnt_a == '0);
          drv_d = rbyte[DW-1];
          sh_d = {rbyte[DW-2:0], 1'b0};
          cnt_d = cnt_a + 1'b1;
          if (cnt_a == LAST) st_d = ST_MACK;
        end
        ST_MACK: begin
          cnt_d = '0;
          if (sda_i) begin
            req_mnack = 1'b1;
            st_d = ST_PARK;
          end else begin
            st_d = ST_RBIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      av_q  <= 1'b0;
      rd_q  <= 1'b0;
      drv_q <= 1'b1;
      sda_o <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      av_q  <= av_d;
      rd_q  <= rd_d;
      drv_q <= drv_d;
      sda_o <= drv_d & sda_i;
    end
  end

  a_r1_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_start, req_write, req_fetch, req_mnack}));
  a_r6_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    scl_fall |=> drv_q);
  a_r6_ack_drives_low: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && st_q == ST_WACK && !rsp_nack) |=> !drv_q);
  a_r3_end_needs_addr: assert property (@(posedge clk) disable iff (rst)
    req_end |-> (av_q || req_start));
  a_r9_parked_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PARK && !cond_start && !cond_stop)
      |-> !(req_start || req_write || req_fetch || req_mnack || req_end));
  a_r7_reject_idles: assert property (@(posedge clk) disable iff (rst)
    ((req_start || req_write) && rsp_nack) |=> (st_q == ST_IDLE && drv_q));
endmodule

// File: rtl/i2c_xact_bridge.sv
module i2c_xact_bridge #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  output logic          req_start,
  output logic [DW-2:0] req_addr,
  output logic          req_read,
  output logic          req_write,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_nack,
  output logic          req_fetch,
  input  logic [DW-1:0] rsp_rdata,
  output logic          req_mnack,
  output logic          req_end
);
  logic scl_q, sda_q, scl_rise, scl_fall, sda_chg, cond_start, cond_stop;

  i2cb_lines u_lines (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_chg(sda_chg), .cond_start(cond_start), .cond_stop(cond_stop)
  );

  i2cb_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst(rst), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .cond_start(cond_start), .cond_stop(cond_stop),
    .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
    .req_start(req_start), .req_addr(req_addr), .req_read(req_read),
    .req_write(req_write), .req_wdata(req_wdata), .req_fetch(req_fetch),
    .req_mnack(req_mnack), .req_end(req_end), .sda_o(sda_o)
  );

  a_r4_low_clock_quiet: assert property (@(posedge clk) disable iff (rst)
    (sda_chg && !scl_q && !scl_i)
      |-> !(req_start || req_write || req_fetch || req_mnack || req_end));
  a_r11_host_low_wins: assert property (@(posedge clk) disable iff (rst)
    !sda_i |=> !sda_o);
endmodule

// File: tb/i2c_xact_bridge_tb.sv
module i2c_xact_bridge_tb;
  localparam int DW = 8;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic sda_o, req_start, req_read, req_write, req_fetch, req_mnack, req_end, rsp_nack;
  logic [DW-2:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;
  logic [DW-1:0] rd_pat = 8'hB6;

  always #5 clk = ~clk;

  i2c_xact_bridge #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_o),
    .req_start(req_start), .req_addr(req_addr), .req_read(req_read),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_nack(rsp_nack),
    .req_fetch(req_fetch), .rsp_rdata(rsp_rdata), .req_mnack(req_mnack),
    .req_end(req_end)
  );

  // downstream model: only DEV answers, byte FF is refused
  assign rsp_nack  = (req_start && req_addr != DEV) || (req_write && req_wdata == 8'hFF);
  assign rsp_rdata = rd_pat;

  int checks = 0, fails = 0;
  int n_start = 0, n_write = 0, n_fetch = 0, n_mnack = 0, n_end = 0, n_any = 0;
  logic [6:0] last_addr;
  logic last_rd;
  logic [7:0] last_wdata;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    bit fetched;
    @(negedge clk);
    scl_i = c;
    sda_i = d;
    #1;
    fetched = req_fetch;
    if (req_start) begin n_start++; last_addr = req_addr; last_rd = req_read; end
    if (req_write) begin n_write++; last_wdata = req_wdata; end
    if (req_fetch) n_fetch++;
    if (req_mnack) n_mnack++;
    if (req_end) n_end++;
    if (req_start | req_write | req_fetch | req_mnack | req_end) n_any++;
    @(posedge clk);
    #1;
    if (fetched) rd_pat = rd_pat + 8'h35;
  endtask

  task automatic bit_x(input logic d, output logic r);
    step(1'b0, d);
    step(1'b1, d);
    r = sda_o;
    step(1'b0, d);
  endtask

  task automatic do_start();
    step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit noisy, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      if (noisy) begin step(1'b0, ~b[i]); step(1'b0, b[i]); end
      bit_x(b[i], r);
    end
    bit_x(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      b[i] = r;
    end
    bit_x(host_ack ? 1'b0 : 1'b1, r);
  endtask

  // {address, data byte, address accepted, data accepted}
  localparam logic [16:0] VEC [0:3] = '{
    {7'h2A, 8'h5C, 1'b1, 1'b1},
    {7'h2A, 8'hFF, 1'b1, 1'b0},
    {7'h13, 8'h00, 1'b0, 1'b0},
    {7'h2A, 8'hA3, 1'b1, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int s0, w0, e0, a0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sda_o in reset", sda_o, 1);
    @(negedge clk); rst = 1'b0;
    step(1'b1, 1'b1);
    chk("R1 sda_o after reset", sda_o, 1);
    chk("R1 no requests", n_any, 0);

    // R4 / R11: data moves while clock low
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R11 host low pulls sda_o", sda_o, 0);
    step(1'b0, 1'b1);
    chk("R4 low-clock data change quiet", n_any, 0);
    chk("R4 drive kept released", sda_o, 1);
    step(1'b1, 1'b1);

    // R3: stop without an address closes nothing
    do_start();
    do_stop();
    chk("R3 stop without address", n_end, 0);

    // table of write transactions
    for (int k = 0; k < 4; k++) begin
      s0 = n_start; w0 = n_write; e0 = n_end;
      do_start();
      send_byte({VEC[k][16:10], 1'b0}, 0, ack);
      chk("R6 address ack", ack, VEC[k][1]);
      chk("R6 released after ack clock", sda_o, 1);
      chk("R5 start request", n_start - s0, 1);
      chk("R5 address field", last_addr, VEC[k][16:10]);
      chk("R5 write direction", last_rd, 0);
      send_byte(VEC[k][9:2], 0, ack);
      chk("R7 data ack", ack, VEC[k][0]);
      chk("R5 write request count", n_write - w0, VEC[k][1]);
      if (VEC[k][1]) chk("R5 write data", last_wdata, VEC[k][9:2]);
      do_stop();
      chk("R7 one end per transfer", n_end - e0, 1);
    end

    // R10: both lines fall together from idle -> start first
    s0 = n_start;
    step(1'b0, 1'b0);
    send_byte({DEV, 1'b0}, 0, ack);
    chk("R10 simultaneous fall is start", ack, 1);
    chk("R10 start request issued", n_start - s0, 1);
    // R4: glitches on data while clock low inside a byte
    e0 = n_end; s0 = n_start;
    send_byte(8'h81, 1, ack);
    chk("R4 noisy byte acked", ack, 1);
    chk("R4 noisy byte value", last_wdata, 8'h81);
    chk("R4 no stray start/stop", (n_end - e0) + (n_start - s0), 0);
    // R2: repeated start, next byte is an address again
    do_start();
    send_byte({DEV, 1'b1}, 0, ack);
    chk("R2 repeated start address ack", ack, 1);
    chk("R2 repeated start read flag", last_rd, 1);
    chk("R2 repeated start request", n_start - s0, 1);
    // R8: read two bytes, host acks first, refuses second
    recv_byte(1'b1, b);
    chk("R8 first read byte", b, 8'hB6);
    recv_byte(1'b0, b);
    chk("R9 second read byte after host ack", b, 8'hEB);
    chk("R8 fetch count", n_fetch, 2);
    chk("R9 master nack request", n_mnack, 1);
    a0 = n_any; e0 = n_end;
    for (int j = 0; j < 3; j++) begin
      logic r;
      bit_x(1'b1, r);
      chk("R9 parked sda_o", r, 1);
    end
    chk("R9 parked no requests", n_any - a0, 0);
    do_stop();
    chk("R9 stop after park ends transfer", n_end - e0, 1);

    // R7: after reject, clocks ignored until start
    do_start();
    send_byte({7'h55, 1'b0}, 0, ack);
    a0 = n_any;
    send_byte(8'h00, 0, ack);
    chk("R7 clocks ignored after reject", n_any - a0, 0);
    chk("R7 no ack after reject", ack, 0);
    do_stop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule